// File: doc/BRIEF.md
# External Count Pin Synchronizer and Edge Detector

This block takes an external count pin that has no timing relationship to the system clock and brings it into the clock domain. Its first stage captures the pin at the end of each clock-high phase, which gives the behaviour of a latch that is open while the clock is high. A rising-edge register follows it and produces the synchronized pin level. A small tracking state machine then compares each new synchronized level with the one before it. When the change matches the polarity that has been selected, the block emits a tick that is one clock cycle wide.

The tick is registered. It rises at a clock edge between 1.5 and 2.5 cycles after the pin edge. A counter that samples the tick therefore counts 2.5 to 3.5 cycles after the pin edge, and the exact figure depends on where in the clock period the pin changed. After reset the state machine spends a short arming period learning the pin level. During that period it emits no tick, so a pin that is already at the selected level does not produce a spurious count.

State machine: `ST_ARM` (reset state, counting `ARM_CYCLES` cycles), `ST_LOW` and `ST_HIGH` (the last synchronized level seen). The transitions are:
- `ST_ARM`→`ST_LOW` or `ST_HIGH` when the arming count expires, according to the synchronized level.
- `ST_LOW`→`ST_HIGH` when the synchronized level becomes 1. This is a rising-edge hit.
- `ST_HIGH`→`ST_LOW` when the synchronized level becomes 0. This is a falling-edge hit.

Top module: `ext_pin_edge_sync`

## Requirements
- R1: While `rst_n` is low, `tick` and `pin_sync` are 0, whatever the pin level.
- R2: After a pin change, `pin_sync` takes the new level at the first rising clock edge that follows the first falling clock edge after the change.
- R3: Each selected pin edge produces exactly one tick, and the tick is one cycle wide.
- R4: When `edge_rise` = 1, ticks come only from 0→1 pin transitions. A 1→0 transition gives none.
- R5: When `edge_rise` = 0, ticks come only from 1→0 pin transitions. A 0→1 transition gives none.
- R6: A tick rises at a clock edge 1.5 to 2.5 cycles after the pin edge. A counter that samples the tick therefore updates 2.5 to 3.5 cycles after the pin edge.
- R7: After reset is released, no tick appears while the pin holds a constant level, even if that level is the selected one.
- R8: Changing `edge_rise` while the pin is stable produces no tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_raw | input | 1 | Asynchronous external count pin |
| edge_rise | input | 1 | 1 = count rising edges, 0 = count falling edges |
| pin_sync | output | 1 | Pin level in the clock domain |
| tick | output | 1 | One-cycle pulse for each selected pin edge |

## Verification
The assertions assume two things about the inputs. `edge_rise` behaves as a synchronous control and does not change at a clock edge. The pin holds each level for at least two clock periods, so every level reaches the synchronized output. The stimulus follows both assumptions. It changes `edge_rise` a fraction of a nanosecond after a rising edge. It moves the pin at sub-cycle offsets that avoid both clock edges. It holds each pin level for at least two cycles.

// File: rtl/epin_pkg.sv
package epin_pkg;

    typedef enum logic [1:0] {
        ST_ARM  = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } trk_state_e;

    typedef enum logic {
        POL_FALL = 1'b0,
        POL_RISE = 1'b1
    } edge_pol_e;

endpackage

// File: rtl/epin_half_capture.sv
// First stage: holds the pin value present at the end of the clock-high
// phase, equivalent to a latch transparent while clk is high.
module epin_half_capture (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic q_out
);

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_out <= 1'b0;
        end else begin
            q_out <= d_in;
        end
    end

endmodule

// File: rtl/epin_sync_stage.sv
// Second stage: rising-edge register producing the synchronized level.
module epin_sync_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic q_out
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_out <= 1'b0;
        end else begin
            q_out <= d_in;
        end
    end

endmodule

// File: rtl/epin_edge_fsm.sv
// Tracks the last synchronized level; a change of level that matches the
// selected polarity produces a registered one-cycle tick.
module epin_edge_fsm
    import epin_pkg::*;
#(
    parameter int ARM_CYCLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_in,
    input  logic rise_sel,
    output logic tick_o
);

    localparam int CW = (ARM_CYCLES < 2) ? 1 : $clog2(ARM_CYCLES);
    localparam logic [CW-1:0] ARM_LAST = CW'(ARM_CYCLES - 1);

    trk_state_e    state_q, state_d;
    logic [CW-1:0] arm_cnt_q;
    logic          rise_hit, fall_hit;
    logic          tick_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ARM;
        end else begin
            state_q <= state_d;
        end
    end

    // arming counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arm_cnt_q <= '0;
        end else if (state_q == ST_ARM && arm_cnt_q != ARM_LAST) begin
            arm_cnt_q <= arm_cnt_q + 1'b1;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARM: begin
                if (arm_cnt_q == ARM_LAST) begin
                    state_d = lvl_in ? ST_HIGH : ST_LOW;
                end
            end
            ST_LOW: begin
                if (lvl_in) state_d = ST_HIGH;
            end
            ST_HIGH: begin
                if (!lvl_in) state_d = ST_LOW;
            end
            default: state_d = ST_ARM;
        endcase
    end

    // edge comparison against the tracked level
    always_comb begin
        rise_hit = (state_q == ST_LOW)  &&  lvl_in;
        fall_hit = (state_q == ST_HIGH) && !lvl_in;
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_q <= 1'b0;
        end else if (edge_pol_e'(rise_sel) == POL_RISE) begin
            tick_q <= rise_hit;
        end else begin
            tick_q <= fall_hit;
        end
    end

    assign tick_o = tick_q;

    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tick_q |=> !tick_q); // R3

    AST_ARM_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(state_q == ST_ARM) |-> !tick_q); // R7

endmodule

// File: rtl/ext_pin_edge_sync.sv
module ext_pin_edge_sync
    import epin_pkg::*;
#(
    parameter int ARM_CYCLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_raw,
    input  logic edge_rise,
    output logic pin_sync,
    output logic tick
);

    logic half_q;

    epin_half_capture u_half (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (pin_raw),
        .q_out (half_q)
    );

    epin_sync_stage u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (half_q),
        .q_out (pin_sync)
    );

    epin_edge_fsm #(
        .ARM_CYCLES (ARM_CYCLES)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl_in   (pin_sync),
        .rise_sel (edge_rise),
        .tick_o   (tick)
    );

    AST_TICK_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> ($past(pin_sync) != $past(pin_sync, 2))); // R3

    AST_RISE_POLARITY: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && $past(edge_rise)) |-> $past(pin_sync)); // R4

    AST_FALL_POLARITY: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !$past(edge_rise)) |-> !$past(pin_sync)); // R5

endmodule

// File: tb/tb_ext_pin_edge_sync.sv
`timescale 1ns/1ps
module tb_ext_pin_edge_sync;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pin_raw = 1'b0;
    logic edge_rise = 1'b1;
    logic pin_sync;
    logic tick;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 0;

    always #2 clk = ~clk;   // 250 MHz

    ext_pin_edge_sync #(.ARM_CYCLES(3)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_raw   (pin_raw),
        .edge_rise (edge_rise),
        .pin_sync  (pin_sync),
        .tick      (tick)
    );

    // vectors: polarity, new pin level, offset after rising edge (ps), tick expected
    localparam int NV = 12;
    localparam logic VRISE [NV] = '{1, 1, 1, 1, 0, 0, 0, 0, 1, 1, 0, 0};
    localparam logic VLVL  [NV] = '{1, 0, 1, 0, 1, 0, 1, 0, 1, 0, 1, 0};
    localparam int   VOFF  [NV] = '{300, 2100, 1900, 3700, 1100, 2900,
                                    500, 2300, 3300, 700, 1500, 3100};
    localparam logic VEXP  [NV] = '{1, 0, 1, 0, 0, 1, 0, 1, 1, 0, 0, 1};

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    task automatic sample_point();
        @(negedge clk);
        #0.1;
    endtask

    initial begin
        #(100000 * 4);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            summary();
            $finish;
        end
    end

    initial begin
        int tick_cnt;
        real t_edge;
        real lat;

        // R1: reset with pin high
        pin_raw   = 1'b1;
        edge_rise = 1'b1;
        repeat (3) sample_point();
        check(tick == 1'b0, "R1 tick in reset", int'(tick), 0);
        check(pin_sync == 1'b0, "R1 pin_sync in reset", int'(pin_sync), 0);

        // R7: release with pin already at selected level
        @(posedge clk);
        #1 rst_n = 1'b1;
        for (int c = 0; c < 8; c++) begin
            sample_point();
            check(tick == 1'b0, "R7 no tick after reset", int'(tick), 0);
        end
        check(pin_sync == 1'b1, "R2 level after reset", int'(pin_sync), 1);

        // R4: falling edge in rise mode gives nothing
        @(posedge clk);
        #1 pin_raw = 1'b0;
        for (int c = 0; c < 6; c++) begin
            sample_point();
            check(tick == 1'b0, "R4 no tick on fall in rise mode", int'(tick), 0);
        end

        // vector table
        for (int v = 0; v < NV; v++) begin
            logic old_lvl;
            old_lvl = pin_raw;
            @(posedge clk);
            #0.1 edge_rise = VRISE[v];
            #((real'(VOFF[v]) / 1000.0) - 0.1);
            pin_raw = VLVL[v];
            t_edge = $realtime;
            for (int k = 1; k <= 5; k++) begin
                logic exp_t;
                sample_point();
                exp_t = (k == 3) && VEXP[v];
                // R3 R4 R5: one tick, correct polarity
                check(tick == exp_t, VRISE[v] ? "R3/R4 tick" : "R3/R5 tick",
                      int'(tick), int'(exp_t));
                if (k == 1)
                    check(pin_sync == old_lvl, "R2 pin_sync not yet", int'(pin_sync), int'(old_lvl));
                if (k == 2)
                    check(pin_sync == VLVL[v], "R2 pin_sync updated", int'(pin_sync), int'(VLVL[v]));
                if (k == 3 && tick) begin
                    lat = $realtime - 2.1 - t_edge;
                    check(lat >= 6.0 && lat <= 10.0, "R6 latency ps",
                          int'(lat * 1000.0), 8000);
                end
            end
        end

        // R8: flip polarity with stable pin
        for (int c = 0; c < 8; c++) begin
            @(posedge clk);
            #0.5 edge_rise = ~edge_rise;
            sample_point();
            check(tick == 1'b0, "R8 polarity change alone", int'(tick), 0);
        end

        // R3: dense train, pin toggles every 2 cycles, rise mode
        @(posedge clk);
        #0.5 edge_rise = 1'b1;
        tick_cnt = 0;
        pin_raw = 1'b0;
        for (int c = 0; c < 24; c++) begin
            @(posedge clk);
            if (c < 16 && c % 2 == 0) begin
                #1.3 pin_raw = ~pin_raw;
            end
            sample_point();
            if (tick) tick_cnt++;
        end
        check(tick_cnt == 4, "R3 tick count on toggle train", tick_cnt, 4);

        // R1: reset asserted mid-run clears outputs
        #0.4 rst_n = 1'b0;
        #0.5;
        check(tick == 1'b0 && pin_sync == 1'b0, "R1 async reset",
              int'({pin_sync, tick}), 0);

        done = 1;
        summary();
        $finish;
    end

endmodule